// File: doc/BRIEF.md
# DDR SDRAM Mode Register Command Tracker

This block watches the command pins of a DDR SDRAM interface and follows the programming of the base and extended mode registers. A register-set command is recognised when chip select, row strobe, column strobe and write enable are all low in the same clock. The bank-address pins then choose the target register. The tracker accepts such a write only when it is legal. It keeps the decoded read latency, burst length and burst ordering, and it emits a one-cycle pulse when a write asks for a DLL reset.

Protocol misuse sets sticky error flags. The misuse it detects is a write with a bank open or with clock enable not already high, any command in the cycle that completes a write, a reserved code, test mode, and a base-register write before the extended register has been set. A rejected write never changes the stored contents. The block fits in a device model or sits beside a controller as a protocol monitor. All outputs are registered and change at the clock edge that samples the command.

Top module: `ddr_mode_tracker`

## Requirements
- R1: A register-set command is all of cs_n, ras_n, cas_n, we_n low with ba[1]=0. ba[0]=0 targets the base register and ba[0]=1 targets the extended register. An accepted extended write stores addr on ext_mode and sets ext_valid. A set command with ba[1]=1 changes no state and raises no error, unless it falls in the busy cycle of R3.
- R2: A set command is accepted only if every bank_idle bit is 1 and cke was 1 both in the previous cycle and in the current one. Otherwise err_state is set and the stored contents are unchanged.
- R3: The cycle after an accepted write is busy. In that cycle, any command with cs_n low other than a NOP (ras_n, cas_n and we_n all high) sets err_timing, and a set command issued there is rejected.
- R4: The burst-length code addr[2:0] maps 001 to 2, 010 to 4 and 011 to 8, and burst_len shows that value. The outputs hold their value except after an accepted base write.
- R5: The latency code addr[6:4] maps 010 to 4, 110 to 5 and 011 to 6 on cas_lat_half, in half-cycle units.
- R6: addr[3] sets burst_interleave: 0 selects sequential, 1 selects interleaved.
- R7: On a base write, a burst-length code or latency code outside R4/R5, or any nonzero bit in addr[ADDR_W-1:9], sets err_reserved and rejects the write.
- R8: On a base write, addr[7]=1 (test mode) sets err_test and rejects the write.
- R9: A base write before any accepted extended write sets err_order and is rejected.
- R10: An accepted base write with addr[8]=1 raises dll_reset_pulse for exactly the next cycle.
- R11: configured rises with the first accepted base write and stays high until reset. Later legal writes replace the fields.
- R12: Error flags are sticky. A clr_err cycle clears them, but an error detected in that same cycle is still recorded.
- R13: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_err | input | 1 | Clears the sticky error flags |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | ADDR_W | Address pins carrying the register value |
| bank_idle | input | NUM_BANKS | One bit per bank, 1 = precharged and idle |
| cas_lat_half | output | 4 | Read latency in half cycles, 0 until configured |
| burst_len | output | 4 | Burst length in beats, 0 until configured |
| burst_interleave | output | 1 | 1 = interleaved burst order |
| dll_reset_pulse | output | 1 | One-cycle DLL reset request |
| configured | output | 1 | A legal base write has been accepted |
| ext_valid | output | 1 | The extended register has been written |
| ext_mode | output | ADDR_W | Last accepted extended register value |
| err_state | output | 1 | Write with a bank open or cke not already high |
| err_timing | output | 1 | Command during the busy cycle |
| err_reserved | output | 1 | Reserved code in a base write |
| err_test | output | 1 | Test mode requested |
| err_order | output | 1 | Base write before the extended write |

## Verification
A wrong busy flag shows in the cycle right after an accepted write: a legal back-to-back write either slips through or is wrongly flagged as err_timing. A wrong clock-enable history or extended-valid bit turns the next set command into a false err_state or err_order, or hides a real one. Both appear at the edge that samples that command. Faulty field storage appears on cas_lat_half, burst_len or burst_interleave at the edge of the write itself, or at any later edge if the fields drift. The per-clock reference comparison catches each of these within one cycle.

// File: rtl/mrt_pkg.sv
package mrt_pkg;

    localparam int LAT_W = 4;
    localparam int BL_W  = 4;

    typedef struct packed {
        logic non_nop;
        logic set_any;
        logic to_ext;
    } cmd_t;

    typedef struct packed {
        logic [LAT_W-1:0] lat_half;
        logic [BL_W-1:0]  blen;
        logic             interleave;
        logic             lat_ok;
        logic             blen_ok;
        logic             rfu_clear;
        logic             test_req;
        logic             dll_req;
    } mode_fields_t;

    typedef struct packed {
        logic state;
        logic timing;
        logic reserved;
        logic test;
        logic order;
    } err_t;

    function automatic logic [BL_W-1:0] blen_of(input logic [2:0] code);
        case (code)
            3'b001:  return BL_W'(2);
            3'b010:  return BL_W'(4);
            3'b011:  return BL_W'(8);
            default: return '0;
        endcase
    endfunction

    function automatic logic [LAT_W-1:0] lat_of(input logic [2:0] code);
        case (code)
            3'b010:  return LAT_W'(4);
            3'b011:  return LAT_W'(6);
            3'b110:  return LAT_W'(5);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/mrt_cmd_decode.sv
module mrt_cmd_decode
    import mrt_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [1:0]        ba,
    input  logic [ADDR_W-1:0] addr,
    output cmd_t              cmd,
    output mode_fields_t      fields
);
    always_comb begin
        cmd.non_nop = !cs_n && !(ras_n && cas_n && we_n);
        cmd.set_any = !cs_n && !ras_n && !cas_n && !we_n && !ba[1];
        cmd.to_ext  = ba[0];
    end

    always_comb begin
        fields.blen       = blen_of(addr[2:0]);
        fields.lat_half   = lat_of(addr[6:4]);
        fields.blen_ok    = (fields.blen != '0);
        fields.lat_ok     = (fields.lat_half != '0);
        fields.interleave = addr[3];
        fields.test_req   = addr[7];
        fields.dll_req    = addr[8];
        fields.rfu_clear  = (addr[ADDR_W-1:9] == '0);
    end
endmodule

// File: rtl/mrt_guard.sv
module mrt_guard
    import mrt_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr_err,
    input  logic                 cke,
    input  logic [NUM_BANKS-1:0] bank_idle,
    input  cmd_t                 cmd,
    input  mode_fields_t         fields,
    input  logic                 ext_seen,
    output logic                 base_ok,
    output logic                 ext_ok,
    output err_t                 err_q
);
    logic cke_prev_q;
    logic busy_q;
    err_t err_new;

    always_comb begin
        err_new = '0;
        base_ok = 1'b0;
        ext_ok  = 1'b0;
        if (busy_q) begin
            err_new.timing = cmd.non_nop;
        end else if (cmd.set_any) begin
            if (!(&bank_idle) || !(cke && cke_prev_q)) begin
                err_new.state = 1'b1;
            end else if (cmd.to_ext) begin
                ext_ok = 1'b1;
            end else begin
                err_new.order    = !ext_seen;
                err_new.reserved = !fields.blen_ok || !fields.lat_ok || !fields.rfu_clear;
                err_new.test     = fields.test_req;
                base_ok = !(err_new.order || err_new.reserved || err_new.test);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cke_prev_q <= 1'b0;
            busy_q     <= 1'b0;
            err_q      <= '0;
        end else begin
            cke_prev_q <= cke;
            busy_q     <= base_ok || ext_ok;
            err_q      <= (clr_err ? '0 : err_q) | err_new;
        end
    end
endmodule

// File: rtl/mrt_regs.sv
module mrt_regs
    import mrt_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_ok,
    input  logic              ext_ok,
    input  mode_fields_t      fields,
    input  logic [ADDR_W-1:0] addr,
    output logic [LAT_W-1:0]  lat_half_q,
    output logic [BL_W-1:0]   blen_q,
    output logic              interleave_q,
    output logic              dll_q,
    output logic              cfg_q,
    output logic              ext_seen_q,
    output logic [ADDR_W-1:0] ext_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_half_q   <= '0;
            blen_q       <= '0;
            interleave_q <= 1'b0;
            dll_q        <= 1'b0;
            cfg_q        <= 1'b0;
            ext_seen_q   <= 1'b0;
            ext_q        <= '0;
        end else begin
            dll_q <= base_ok && fields.dll_req;
            if (base_ok) begin
                lat_half_q   <= fields.lat_half;
                blen_q       <= fields.blen;
                interleave_q <= fields.interleave;
                cfg_q        <= 1'b1;
            end
            if (ext_ok) begin
                ext_q      <= addr;
                ext_seen_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ddr_mode_tracker.sv
module ddr_mode_tracker
    import mrt_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_BANKS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr_err,
    input  logic                 cke,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [1:0]           ba,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_BANKS-1:0] bank_idle,
    output logic [LAT_W-1:0]     cas_lat_half,
    output logic [BL_W-1:0]      burst_len,
    output logic                 burst_interleave,
    output logic                 dll_reset_pulse,
    output logic                 configured,
    output logic                 ext_valid,
    output logic [ADDR_W-1:0]    ext_mode,
    output logic                 err_state,
    output logic                 err_timing,
    output logic                 err_reserved,
    output logic                 err_test,
    output logic                 err_order
);
    cmd_t         cmd;
    mode_fields_t fields;
    logic         base_ok;
    logic         ext_ok;
    err_t         err_q;

    mrt_cmd_decode #(.ADDR_W(ADDR_W)) dec_i (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .cmd(cmd), .fields(fields)
    );

    mrt_guard #(.NUM_BANKS(NUM_BANKS)) guard_i (
        .clk(clk), .rst(rst), .clr_err(clr_err), .cke(cke),
        .bank_idle(bank_idle), .cmd(cmd), .fields(fields),
        .ext_seen(ext_valid), .base_ok(base_ok), .ext_ok(ext_ok),
        .err_q(err_q)
    );

    mrt_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst(rst), .base_ok(base_ok), .ext_ok(ext_ok),
        .fields(fields), .addr(addr),
        .lat_half_q(cas_lat_half), .blen_q(burst_len),
        .interleave_q(burst_interleave), .dll_q(dll_reset_pulse),
        .cfg_q(configured), .ext_seen_q(ext_valid), .ext_q(ext_mode)
    );

    assign err_state    = err_q.state;
    assign err_timing   = err_q.timing;
    assign err_reserved = err_q.reserved;
    assign err_test     = err_q.test;
    assign err_order    = err_q.order;
endmodule

// File: rtl/mrt_checker.sv
module mrt_checker #(
    parameter int NUM_BANKS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 clr_err,
    input logic                 cs_n,
    input logic                 ras_n,
    input logic                 cas_n,
    input logic                 we_n,
    input logic [1:0]           ba,
    input logic [NUM_BANKS-1:0] bank_idle,
    input logic                 base_ok,
    input logic                 ext_ok,
    input logic [3:0]           cas_lat_half,
    input logic [3:0]           burst_len,
    input logic                 dll_reset_pulse,
    input logic                 configured,
    input logic                 ext_valid,
    input logic                 err_state,
    input logic                 err_timing,
    input logic                 err_reserved
);
    // R10
    dll_single_chk: assert property (@(posedge clk) disable iff (rst)
        dll_reset_pulse |=> !dll_reset_pulse);

    // R3
    busy_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (base_ok || ext_ok) |=> !(base_ok || ext_ok));

    // R2
    open_bank_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !ras_n && !cas_n && !we_n && !ba[1] && !(&bank_idle))
        |=> (err_state || err_timing));

    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$fell(configured));

    // R4
    field_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !base_ok |=> ($stable(burst_len) && $stable(cas_lat_half)));

    // R9
    order_chk: assert property (@(posedge clk) disable iff (rst)
        base_ok |-> ext_valid);

    // R12
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_reserved && !clr_err) |=> err_reserved);
endmodule

bind ddr_mode_tracker mrt_checker #(.NUM_BANKS(NUM_BANKS)) chk_i (
    .clk(clk), .rst(rst), .clr_err(clr_err),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .bank_idle(bank_idle), .base_ok(base_ok), .ext_ok(ext_ok),
    .cas_lat_half(cas_lat_half), .burst_len(burst_len),
    .dll_reset_pulse(dll_reset_pulse), .configured(configured),
    .ext_valid(ext_valid), .err_state(err_state), .err_timing(err_timing),
    .err_reserved(err_reserved)
);

// File: tb/ddr_mode_tracker_tb_top.sv
module ddr_mode_tracker_tb_top;
    localparam int AW = 12;
    localparam int NB = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr_err = 1'b0;
    logic cke = 1'b0;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = '0;
    logic [AW-1:0] addr = '0;
    logic [NB-1:0] bank_idle = '1;

    logic [3:0] cas_lat_half, burst_len;
    logic burst_interleave, dll_reset_pulse, configured, ext_valid;
    logic [AW-1:0] ext_mode;
    logic err_state, err_timing, err_reserved, err_test, err_order;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ddr_mode_tracker #(.ADDR_W(AW), .NUM_BANKS(NB)) dut_i (.*);

    // reference model state
    int  m_lat, m_bl;
    bit  m_bt, m_dll, m_cfg, m_extv, m_busy, m_ckep;
    int  m_ext;
    bit  e_state, e_tim, e_res, e_test, e_ord;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit nn, st, rej;
        int bl, lat;
        if (rst) begin
            m_lat = 0; m_bl = 0; m_bt = 0; m_dll = 0; m_cfg = 0; m_extv = 0;
            m_busy = 0; m_ckep = 0; m_ext = 0;
            e_state = 0; e_tim = 0; e_res = 0; e_test = 0; e_ord = 0;
        end else begin
            nn = !cs_n && !(ras_n && cas_n && we_n);
            st = !cs_n && !ras_n && !cas_n && !we_n && !ba[1];
            if (clr_err) begin
                e_state = 0; e_tim = 0; e_res = 0; e_test = 0; e_ord = 0;
            end
            m_dll = 0;
            if (m_busy) begin
                m_busy = 0;
                if (nn) e_tim = 1;
            end else if (st) begin
                if (bank_idle != 4'hF || !(cke && m_ckep)) e_state = 1;
                else if (ba[0]) begin
                    m_ext = int'(addr); m_extv = 1; m_busy = 1;
                end else begin
                    rej = 0;
                    bl = (addr[2:0] == 3'd1) ? 2 : (addr[2:0] == 3'd2) ? 4 :
                         (addr[2:0] == 3'd3) ? 8 : 0;
                    lat = (addr[6:4] == 3'd2) ? 4 : (addr[6:4] == 3'd3) ? 6 :
                          (addr[6:4] == 3'd6) ? 5 : 0;
                    if (!m_extv) begin e_ord = 1; rej = 1; end
                    if (bl == 0 || lat == 0 || addr[11:9] != 0) begin e_res = 1; rej = 1; end
                    if (addr[7]) begin e_test = 1; rej = 1; end
                    if (!rej) begin
                        m_bl = bl; m_lat = lat; m_bt = addr[3]; m_cfg = 1;
                        m_dll = addr[8]; m_busy = 1;
                    end
                end
            end
            m_ckep = cke;
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            check(int'(cas_lat_half) == m_lat, "R5 cas_lat_half", int'(cas_lat_half), m_lat);
            check(int'(burst_len) == m_bl, "R4 burst_len", int'(burst_len), m_bl);
            check(burst_interleave == m_bt, "R6 burst_interleave", int'(burst_interleave), int'(m_bt));
            check(dll_reset_pulse == m_dll, "R10 dll_reset_pulse", int'(dll_reset_pulse), int'(m_dll));
            check(configured == m_cfg, "R11 configured", int'(configured), int'(m_cfg));
            check(ext_valid == m_extv && int'(ext_mode) == m_ext, "R1 ext_mode",
                  int'(ext_mode), m_ext);
            check(err_state == e_state, "R2 err_state", int'(err_state), int'(e_state));
            check(err_timing == e_tim, "R3 err_timing", int'(err_timing), int'(e_tim));
            check(err_reserved == e_res, "R7 err_reserved", int'(err_reserved), int'(e_res));
            check(err_test == e_test, "R8 err_test", int'(err_test), int'(e_test));
            check(err_order == e_ord, "R9 err_order", int'(err_order), int'(e_ord));
        end
    end

    function automatic logic [AW-1:0] mk(input int lat, input bit bt, input int bl,
                                         input bit tm, input bit dll);
        return AW'((int'(dll) << 8) | (int'(tm) << 7) | (lat << 4) | (int'(bt) << 3) | bl);
    endfunction

    // drive one command for a cycle, then return to deselect
    task automatic issue(input logic [3:0] c, input logic [1:0] b, input logic [AW-1:0] a);
        {cs_n, ras_n, cas_n, we_n} = c;
        ba = b; addr = a;
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = 4'b1111;
        ba = '0; addr = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear;
        clr_err = 1'b1;
        @(negedge clk);
        clr_err = 1'b0;
    endtask

    localparam logic [3:0] SET = 4'b0000;
    localparam logic [3:0] ACT = 4'b0011;
    localparam logic [3:0] NOPC = 4'b0111;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R13 reset state
        check(cas_lat_half == 0 && burst_len == 0 && !configured && !ext_valid &&
              !err_state && !err_order && !dll_reset_pulse, "R13 reset", int'(configured), 0);
        // cke low: R2
        issue(SET, 2'b01, 12'h001);
        check(err_state && !ext_valid, "R2 cke low", int'(err_state), 1);
        cke = 1'b1;
        idle(1);
        clear();
        // base before extended: R9
        issue(SET, 2'b00, mk(3, 0, 2, 0, 0));
        check(err_order && !configured, "R9 order", int'(err_order), 1);
        clear();
        // extended write: R1
        issue(SET, 2'b01, 12'h002);
        check(ext_valid && ext_mode == 12'h002, "R1 ext", int'(ext_mode), 2);
        idle(1);
        // base write CL3 BL4 seq with DLL reset: R4 R5 R10 R11
        issue(SET, 2'b00, mk(3, 0, 2, 0, 1));
        check(cas_lat_half == 6 && burst_len == 4 && configured, "R5 cl3", int'(cas_lat_half), 6);
        check(dll_reset_pulse, "R10 pulse", int'(dll_reset_pulse), 1);
        // busy cycle: activate -> R3
        issue(ACT, 2'b00, 12'h000);
        check(err_timing && !dll_reset_pulse, "R3 act in busy", int'(err_timing), 1);
        clear();
        // accepted write then immediate set: rejected
        issue(SET, 2'b00, mk(6, 1, 3, 0, 0));
        check(cas_lat_half == 5 && burst_len == 8 && burst_interleave, "R6 interleave", int'(burst_interleave), 1);
        issue(SET, 2'b00, mk(2, 0, 1, 0, 0));
        check(err_timing && cas_lat_half == 5, "R3 set in busy", int'(cas_lat_half), 5);
        // NOP in busy is fine
        clear();
        issue(SET, 2'b00, mk(2, 0, 1, 0, 0));
        check(cas_lat_half == 4 && burst_len == 2 && !burst_interleave, "R4 bl2", int'(burst_len), 2);
        issue(NOPC, 2'b00, 12'h000);
        check(!err_timing, "R3 nop ok", int'(err_timing), 0);
        // reserved codes: R7
        issue(SET, 2'b00, mk(3, 0, 0, 0, 0));
        check(err_reserved && burst_len == 2, "R7 bl000", int'(burst_len), 2);
        idle(1);
        clear();
        issue(SET, 2'b00, mk(1, 0, 3, 0, 0));
        check(err_reserved && cas_lat_half == 4, "R7 cl001", int'(cas_lat_half), 4);
        clear();
        issue(SET, 2'b00, mk(3, 0, 3, 0, 0) | 12'h200);
        check(err_reserved && burst_len == 2, "R7 rfu", int'(burst_len), 2);
        // R12 sticky
        idle(2);
        check(err_reserved, "R12 sticky", int'(err_reserved), 1);
        clear();
        // test mode: R8
        issue(SET, 2'b00, mk(3, 0, 3, 1, 0));
        check(err_test && !err_reserved && burst_len == 2, "R8 test", int'(err_test), 1);
        clear();
        // open bank: R2
        bank_idle = 4'b1011;
        issue(SET, 2'b00, mk(3, 0, 3, 0, 0));
        check(err_state && burst_len == 2, "R2 open bank", int'(burst_len), 2);
        bank_idle = 4'hF;
        clear();
        // ba[1]=1 ignored: R1
        issue(SET, 2'b10, mk(3, 0, 3, 0, 0));
        check(!err_state && !err_reserved && burst_len == 2 && ext_mode == 12'h002,
              "R1 ba1 ignored", int'(burst_len), 2);
        // clear with simultaneous error: R12
        clr_err = 1'b1;
        issue(SET, 2'b00, mk(3, 0, 3, 1, 0));
        clr_err = 1'b0;
        check(err_test, "R12 clear vs new", int'(err_test), 1);
        clear();
        check(!err_test, "R12 cleared", int'(err_test), 0);
        // rewrite during operation: R11
        issue(SET, 2'b00, mk(3, 1, 3, 0, 0));
        check(configured && cas_lat_half == 6 && burst_len == 8, "R11 rewrite", int'(burst_len), 8);
        idle(3);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule